// File: doc/BRIEF.md
# Node Cache Coherence Controller

This block is the cache-side agent of one processing node in a multiprocessor whose coherence is kept by a home directory. It holds a small direct-mapped cache. Each line carries a tag, one data word and a state of Invalid, Shared or Exclusive. Loads and stores from the local processor are served from the cache when the line allows it. When it does not, the block sends a miss message naming this node and the address to the home directory and waits for the data reply.

The directory in turn sends commands to the node. These can invalidate a copy, fetch the value of an owned line (the owner keeps a readable copy), or fetch the value and drop the line. When a miss lands on a line that holds a different block in Exclusive state, the old value is written back before the new block is requested. A Shared victim is dropped silently.

All outgoing traffic uses one message port that carries one message per cycle with no back-pressure. The processor request (`cpu_req`) and the directory command (`cmd_valid`) must be held stable until `cpu_ready` or `cmd_ack` is seen high. A directory reply is accepted only while a miss is pending.

Top module: `coh_node_cache`

## Requirements
- R1: After reset every line is Invalid and `msg_valid`, `cpu_ready` and `cmd_ack` are low, so the first load to any address misses.
- R2: A load that misses raises `msg_valid` in the cycle it is taken, with `msg_kind`=0 (read miss), `msg_node`=NODE_ID and `msg_addr` equal to the load address. `cpu_ready` stays low until the reply.
- R3: In the cycle `rep_valid` is high during a pending load miss, `cpu_ready` is high and `cpu_rdata` equals `rep_data`. The line becomes Shared: a later load to that address completes in its first cycle with no message.
- R4: A store to a line that is absent or Shared sends `msg_kind`=1 (write miss) with the store address. The reply makes the line Exclusive, holding the store data.
- R5: A store to a line held Exclusive completes in its first cycle with `cpu_ready` high and no message, and updates the line data.
- R6: A directory command with `cmd_kind`=0 (invalidate) on a held line is acknowledged in its first cycle with no message, and the line becomes Invalid.
- R7: A command with `cmd_kind`=1 (fetch) on an Exclusive line sends `msg_kind`=3 (data to home) with the command address and the line data in the acknowledge cycle. The line becomes Shared: loads hit, and a store sends a write miss.
- R8: A command with `cmd_kind`=2 (fetch and invalidate) sends a kind-3 data message if the line is Exclusive and none if it is Shared. In both cases the line becomes Invalid.
- R9: A miss whose line holds another address in Exclusive state first sends `msg_kind`=2 (write-back) with the victim address and data. The miss message follows in the next cycle.
- R10: Addresses whose low log2(LINES) bits match share one line. Accessing one evicts the other; a Shared victim is replaced with no write-back, and the evicted address misses afterwards.
- R11: A directory command for an address not held (line Invalid, or a different tag) is acknowledged with no message, and the cache contents are unchanged.
- R12: While a miss is pending no further miss message is sent. Directory commands are still acknowledged in that time, except in a cycle that carries the reply.
- R13: When idle, a directory command takes the cycle ahead of a processor request: `cpu_ready` stays low while `cmd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| msg_valid | output | 1 | Outgoing message this cycle |
| msg_kind | output | 2 | 0 read miss, 1 write miss, 2 write-back, 3 data to home |
| msg_node | output | NODE_W | Identity of this node |
| msg_addr | output | ADDR_W | Address carried by the message |
| msg_data | output | DATA_W | Data for kinds 2 and 3, zero otherwise |
| rep_valid | input | 1 | Data reply from the home directory |
| rep_data | input | DATA_W | Reply data word |
| cmd_valid | input | 1 | Directory command, held until cmd_ack |
| cmd_kind | input | 2 | 0 invalidate, 1 fetch, 2 fetch and invalidate, 3 no operation |
| cmd_addr | input | ADDR_W | Address of the command |
| cmd_ack | output | 1 | Command applied this cycle |

## Verification
The hardest situation to reach is a dirty eviction. A line must first be made Exclusive through a completed write miss. Then a conflicting address with the same index and a different tag must be accessed, so that the write-back and the miss message come out in two consecutive cycles before any reply. The bench builds this state with a store miss, then issues a load to the conflicting address and samples the message port cycle by cycle. In the same way it drives directory commands into the window where a miss is pending, and again in the same cycle as a processor hit, to exercise the arbitration rules.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } line_state_e;

  typedef enum logic [1:0] {
    MK_RD_MISS   = 2'd0,
    MK_WR_MISS   = 2'd1,
    MK_WRBACK    = 2'd2,
    MK_HOME_DATA = 2'd3
  } msg_kind_e;

  typedef enum logic [1:0] {
    CK_INVAL       = 2'd0,
    CK_FETCH       = 2'd1,
    CK_FETCH_INVAL = 2'd2,
    CK_NOP         = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_SEND = 2'd1,
    FS_WAIT = 2'd2
  } fsm_e;

endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
  import coh_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int IDX_W  = $clog2(LINES),
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output line_state_e       rd_a_state,
  output logic [TAG_W-1:0]  rd_a_tag,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output line_state_e       rd_b_state,
  output logic [TAG_W-1:0]  rd_b_tag,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_full,
  input  line_state_e       wr_state,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);

  line_state_e       st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];
  logic [LINES-1:0]  line_sel;

  for (genvar g = 0; g < LINES; g++) begin : g_sel
    assign line_sel[g] = wr_en && (wr_idx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= LS_INV;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (line_sel[i]) begin
          st_q[i] <= wr_state;
          if (wr_full) begin
            tag_q[i] <= wr_tag;
            dat_q[i] <= wr_data;
          end
        end
      end
    end
  end

  assign rd_a_state = st_q[rd_a_idx];
  assign rd_a_tag   = tag_q[rd_a_idx];
  assign rd_a_data  = dat_q[rd_a_idx];
  assign rd_b_state = st_q[rd_b_idx];
  assign rd_b_tag   = tag_q[rd_b_idx];
  assign rd_b_data  = dat_q[rd_b_idx];

  // R3 R4: a fill always installs a readable line
  assert_fill_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_full |-> wr_state != LS_INV);

  // R6: a written state is what the line holds one cycle later
  assert_state_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> st_q[$past(wr_idx)] == $past(wr_state));

endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int LINES   = 4,
  parameter int NODE_W  = 2,
  parameter int NODE_ID = 1,
  parameter int IDX_W   = $clog2(LINES),
  parameter int TAG_W   = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              msg_valid,
  output logic [1:0]        msg_kind,
  output logic [NODE_W-1:0] msg_node,
  output logic [ADDR_W-1:0] msg_addr,
  output logic [DATA_W-1:0] msg_data,
  input  logic              rep_valid,
  input  logic [DATA_W-1:0] rep_data,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_ack,
  output logic [IDX_W-1:0]  ca_idx,
  input  line_state_e       ca_state,
  input  logic [TAG_W-1:0]  ca_tag,
  input  logic [DATA_W-1:0] ca_data,
  output logic [IDX_W-1:0]  cb_idx,
  input  line_state_e       cb_state,
  input  logic [TAG_W-1:0]  cb_tag,
  input  logic [DATA_W-1:0] cb_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              wr_full,
  output line_state_e       wr_state,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data
);

  function automatic logic [IDX_W-1:0] line_idx(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] line_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i);
    return {t, i};
  endfunction

  fsm_e fsm_q, fsm_d;

  // named internal events
  logic cpu_tag_match, cpu_present, cpu_hit, victim_dirty;
  logic cmd_present;
  logic cpu_slot, cmd_slot;
  logic hit_evt, miss_evt, wb_evt, fill_evt, fetch_out, cmd_write;
  msg_kind_e miss_kind, kind_sel;

  assign ca_idx = line_idx(cpu_addr);
  assign cb_idx = line_idx(cmd_addr);

  assign cpu_tag_match = (ca_tag == line_tag(cpu_addr));
  assign cpu_present   = (ca_state != LS_INV) && cpu_tag_match;
  assign cpu_hit       = cpu_present && (!cpu_we || ca_state == LS_EXC);
  assign victim_dirty  = (ca_state == LS_EXC) && !cpu_tag_match;
  assign cmd_present   = (cb_state != LS_INV) && (cb_tag == line_tag(cmd_addr));

  assign cmd_slot = cmd_valid &&
                    (fsm_q == FS_IDLE || (fsm_q == FS_WAIT && !rep_valid));
  assign cpu_slot = cpu_req && fsm_q == FS_IDLE && !cmd_valid;

  assign hit_evt   = cpu_slot && cpu_hit;
  assign miss_evt  = cpu_slot && !cpu_hit;
  assign wb_evt    = miss_evt && victim_dirty;
  assign fill_evt  = (fsm_q == FS_WAIT) && rep_valid;
  assign fetch_out = cmd_slot && cmd_present && cb_state == LS_EXC &&
                     (cmd_kind == CK_FETCH || cmd_kind == CK_FETCH_INVAL);
  assign cmd_write = cmd_slot && cmd_present && cmd_kind != CK_NOP;

  assign miss_kind = cpu_we ? MK_WR_MISS : MK_RD_MISS;

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fsm_q <= FS_IDLE;
    else        fsm_q <= fsm_d;
  end

  always_comb begin
    fsm_d = fsm_q;
    case (fsm_q)
      FS_IDLE: begin
        if (wb_evt)        fsm_d = FS_SEND;
        else if (miss_evt) fsm_d = FS_WAIT;
      end
      FS_SEND: fsm_d = FS_WAIT;
      FS_WAIT: if (fill_evt) fsm_d = FS_IDLE;
      default: fsm_d = FS_IDLE;
    endcase
  end

  // line array write port: the event sources never coincide
  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = ca_idx;
    wr_full  = 1'b0;
    wr_state = LS_INV;
    wr_tag   = line_tag(cpu_addr);
    wr_data  = cpu_wdata;
    if (fill_evt) begin
      wr_en    = 1'b1;
      wr_full  = 1'b1;
      wr_state = cpu_we ? LS_EXC : LS_SHR;
      wr_data  = cpu_we ? cpu_wdata : rep_data;
    end else if (hit_evt && cpu_we) begin
      wr_en    = 1'b1;
      wr_full  = 1'b1;
      wr_state = LS_EXC;
    end else if (miss_evt) begin
      wr_en    = 1'b1;
      wr_state = LS_INV;
    end else if (cmd_write) begin
      wr_en  = 1'b1;
      wr_idx = cb_idx;
      if (cmd_kind == CK_FETCH)
        wr_state = (cb_state == LS_EXC) ? LS_SHR : cb_state;
      else
        wr_state = LS_INV;
    end
  end

  // processor side
  assign cpu_ready = hit_evt || fill_evt;
  assign cpu_rdata = fill_evt ? rep_data : ca_data;
  assign cmd_ack   = cmd_slot;

  // outgoing messages
  always_comb begin
    msg_valid = 1'b0;
    kind_sel  = MK_RD_MISS;
    msg_addr  = cpu_addr;
    msg_data  = '0;
    if (wb_evt) begin
      msg_valid = 1'b1;
      kind_sel  = MK_WRBACK;
      msg_addr  = join_addr(ca_tag, ca_idx);
      msg_data  = ca_data;
    end else if (miss_evt || fsm_q == FS_SEND) begin
      msg_valid = 1'b1;
      kind_sel  = miss_kind;
    end else if (fetch_out) begin
      msg_valid = 1'b1;
      kind_sel  = MK_HOME_DATA;
      msg_addr  = cmd_addr;
      msg_data  = cb_data;
    end
  end

  assign msg_kind = kind_sel;
  assign msg_node = NODE_W'(NODE_ID);

  // R12: no second miss message while one is pending
  assert_one_miss_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_q == FS_WAIT |-> !(msg_valid && (msg_kind == MK_RD_MISS || msg_kind == MK_WR_MISS)));

  // R9: write-back is followed next cycle by the miss message
  assert_wb_then_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == MK_WRBACK |=>
      msg_valid && (msg_kind == MK_RD_MISS || msg_kind == MK_WR_MISS));

  // R2: the processor never completes without a request
  assert_ready_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

  // R5: a store hit on an owned line is silent
  assert_store_hit_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt && cpu_we |-> !msg_valid);

  // R7: data to home only answers an acknowledged command
  assert_home_data_acked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == MK_HOME_DATA |-> cmd_ack);

  // R13: at most one writer of the line array per cycle
  assert_single_writer_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fill_evt, hit_evt && cpu_we, miss_evt, cmd_write}) <= 1);

  // R3: reply only completes a pending miss
  assert_fill_after_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |-> cpu_ready && !cmd_ack);

endmodule

// File: rtl/coh_node_cache.sv
module coh_node_cache
  import coh_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int LINES   = 4,
  parameter int NODE_W  = 2,
  parameter int NODE_ID = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              msg_valid,
  output logic [1:0]        msg_kind,
  output logic [NODE_W-1:0] msg_node,
  output logic [ADDR_W-1:0] msg_addr,
  output logic [DATA_W-1:0] msg_data,
  input  logic              rep_valid,
  input  logic [DATA_W-1:0] rep_data,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_ack
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  ca_idx, cb_idx, wr_idx;
  line_state_e       ca_state, cb_state, wr_state;
  logic [TAG_W-1:0]  ca_tag, cb_tag, wr_tag;
  logic [DATA_W-1:0] ca_data, cb_data, wr_data;
  logic              wr_en, wr_full;

  coh_line_array #(
    .LINES (LINES),
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_idx  (ca_idx),
    .rd_a_state(ca_state),
    .rd_a_tag  (ca_tag),
    .rd_a_data (ca_data),
    .rd_b_idx  (cb_idx),
    .rd_b_state(cb_state),
    .rd_b_tag  (cb_tag),
    .rd_b_data (cb_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_full   (wr_full),
    .wr_state  (wr_state),
    .wr_tag    (wr_tag),
    .wr_data   (wr_data)
  );

  coh_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LINES  (LINES),
    .NODE_W (NODE_W),
    .NODE_ID(NODE_ID),
    .IDX_W  (IDX_W),
    .TAG_W  (TAG_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_we   (cpu_we),
    .cpu_addr (cpu_addr),
    .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata),
    .msg_valid(msg_valid),
    .msg_kind (msg_kind),
    .msg_node (msg_node),
    .msg_addr (msg_addr),
    .msg_data (msg_data),
    .rep_valid(rep_valid),
    .rep_data (rep_data),
    .cmd_valid(cmd_valid),
    .cmd_kind (cmd_kind),
    .cmd_addr (cmd_addr),
    .cmd_ack  (cmd_ack),
    .ca_idx   (ca_idx),
    .ca_state (ca_state),
    .ca_tag   (ca_tag),
    .ca_data  (ca_data),
    .cb_idx   (cb_idx),
    .cb_state (cb_state),
    .cb_tag   (cb_tag),
    .cb_data  (cb_data),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_full  (wr_full),
    .wr_state (wr_state),
    .wr_tag   (wr_tag),
    .wr_data  (wr_data)
  );

  // R1: nothing leaves the block while reset is held
  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (!msg_valid && !cpu_ready && !cmd_ack);
  end

endmodule

// File: tb/test_coh_node_cache.sv
module test_coh_node_cache;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NW = 2;
  localparam int NID = 1;

  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_WB = 2'd2, K_HD = 2'd3;
  localparam logic [1:0] C_INV = 2'd0, C_FETCH = 2'd1, C_FINV = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic msg_valid;
  logic [1:0] msg_kind;
  logic [NW-1:0] msg_node;
  logic [AW-1:0] msg_addr;
  logic [DW-1:0] msg_data;
  logic rep_valid = 1'b0;
  logic [DW-1:0] rep_data = '0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_kind = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic cmd_ack;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  coh_node_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(4), .NODE_W(NW), .NODE_ID(NID))
  i_coh_node_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_node(msg_node),
    .msg_addr(msg_addr), .msg_data(msg_data),
    .rep_valid(rep_valid), .rep_data(rep_data),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_ack(cmd_ack)
  );

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_msg(input string rq, input logic [1:0] k,
                            input logic [AW-1:0] a, input logic [DW-1:0] d);
    chk(rq, "msg_valid", msg_valid, 1);
    chk(rq, "msg_kind", msg_kind, k);
    chk(rq, "msg_node", msg_node, NID);
    chk(rq, "msg_addr", msg_addr, a);
    chk(rq, "msg_data", msg_data, d);
  endtask

  task automatic drive_cpu(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
  endtask

  task automatic finish_fill(input string rq, input logic [DW-1:0] d);
    rep_valid = 1'b1; rep_data = d;
    #1;
    chk(rq, "ready on reply", cpu_ready, 1);
    chk(rq, "rdata on reply", cpu_rdata, d);
    tick();
    rep_valid = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic load_miss(input string rq, input logic [AW-1:0] a, input logic [DW-1:0] d);
    drive_cpu(1'b0, a, '0);
    #1;
    expect_msg(rq, K_RD, a, '0);
    chk(rq, "ready low on miss", cpu_ready, 0);
    tick();
    finish_fill(rq, d);
  endtask

  task automatic store_miss(input string rq, input logic [AW-1:0] a, input logic [DW-1:0] d);
    drive_cpu(1'b1, a, d);
    #1;
    expect_msg(rq, K_WR, a, '0);
    chk(rq, "ready low on miss", cpu_ready, 0);
    tick();
    finish_fill(rq, 16'hF00D);
  endtask

  task automatic load_hit(input string rq, input logic [AW-1:0] a, input logic [DW-1:0] d);
    drive_cpu(1'b0, a, '0);
    #1;
    chk(rq, "hit ready", cpu_ready, 1);
    chk(rq, "hit rdata", cpu_rdata, d);
    chk(rq, "hit silent", msg_valid, 0);
    tick();
    cpu_req = 1'b0;
  endtask

  task automatic dir_cmd(input string rq, input logic [1:0] k, input logic [AW-1:0] a,
                         input logic exp_msg, input logic [DW-1:0] d);
    cmd_valid = 1'b1; cmd_kind = k; cmd_addr = a;
    #1;
    chk(rq, "cmd_ack", cmd_ack, 1);
    chk(rq, "cmd msg_valid", msg_valid, exp_msg);
    if (exp_msg) expect_msg(rq, K_HD, a, d);
    tick();
    cmd_valid = 1'b0;
  endtask

  // R1 R2 R3 R12
  task automatic t_first_miss();
    #1;
    chk("R1", "msg_valid after reset", msg_valid, 0);
    chk("R1", "cpu_ready after reset", cpu_ready, 0);
    chk("R1", "cmd_ack after reset", cmd_ack, 0);
    drive_cpu(1'b0, 8'h11, '0);
    #1;
    expect_msg("R2", K_RD, 8'h11, '0);
    chk("R2", "ready low", cpu_ready, 0);
    tick();
    for (int i = 0; i < 2; i++) begin
      #1;
      chk("R12", "no miss while pending", msg_valid, 0);
      chk("R2", "stall while pending", cpu_ready, 0);
      tick();
    end
    dir_cmd("R12", C_INV, 8'h22, 1'b0, '0);
    finish_fill("R3", 16'hBEEF);
    load_hit("R3", 8'h11, 16'hBEEF);
  endtask

  // R4 R5
  task automatic t_stores();
    store_miss("R4", 8'h11, 16'h1234);
    load_hit("R4", 8'h11, 16'h1234);
    drive_cpu(1'b1, 8'h11, 16'h5678);
    #1;
    chk("R5", "store hit ready", cpu_ready, 1);
    chk("R5", "store hit silent", msg_valid, 0);
    tick();
    cpu_req = 1'b0;
    load_hit("R5", 8'h11, 16'h5678);
  endtask

  // R7 R8 R6
  task automatic t_commands();
    dir_cmd("R7", C_FETCH, 8'h11, 1'b1, 16'h5678);
    load_hit("R7", 8'h11, 16'h5678);
    store_miss("R7", 8'h11, 16'h9ABC);
    dir_cmd("R8", C_FINV, 8'h11, 1'b1, 16'h9ABC);
    load_miss("R8", 8'h11, 16'h4444);
    dir_cmd("R8", C_FINV, 8'h11, 1'b0, '0);
    load_miss("R8", 8'h11, 16'h5555);
    dir_cmd("R6", C_INV, 8'h11, 1'b0, '0);
    load_miss("R6", 8'h11, 16'h6666);
  endtask

  // R11
  task automatic t_unheld();
    dir_cmd("R11", C_FETCH, 8'h21, 1'b0, '0);
    dir_cmd("R11", C_INV, 8'h21, 1'b0, '0);
    load_hit("R11", 8'h11, 16'h6666);
    dir_cmd("R11", C_FINV, 8'h22, 1'b0, '0);
  endtask

  // R9 R10
  task automatic t_evict();
    store_miss("R9", 8'h13, 16'h0C0C);
    drive_cpu(1'b0, 8'h33, '0);
    #1;
    expect_msg("R9", K_WB, 8'h13, 16'h0C0C);
    chk("R9", "ready low on write-back", cpu_ready, 0);
    tick();
    #1;
    expect_msg("R9", K_RD, 8'h33, '0);
    tick();
    finish_fill("R9", 16'h3333);
    load_miss("R10", 8'h13, 16'h1313);
    load_miss("R10", 8'h21, 16'h2121);
    load_miss("R10", 8'h11, 16'h1111);
  endtask

  // R13
  task automatic t_priority();
    drive_cpu(1'b0, 8'h11, '0);
    cmd_valid = 1'b1; cmd_kind = C_INV; cmd_addr = 8'h22;
    #1;
    chk("R13", "cpu held off", cpu_ready, 0);
    chk("R13", "cmd served", cmd_ack, 1);
    tick();
    cmd_valid = 1'b0;
    #1;
    chk("R13", "cpu served after cmd", cpu_ready, 1);
    chk("R13", "rdata after cmd", cpu_rdata, 16'h1111);
    tick();
    cpu_req = 1'b0;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_first_miss();
    t_stores();
    t_commands();
    t_unheld();
    t_evict();
    t_priority();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule